// File: doc/BRIEF.md
# Power-management fixed event and control registers

This block is the fixed-feature power-management register set that an operating system's power code reaches over a small I/O-port bus. The bus carries an address, an access size in bytes, read and write strobes and write data. Four locations are decoded. The first is a 16-bit event status word. The second is a 16-bit event enable word. The third is a 16-bit control word. The fourth is a byte-wide command port that is write-only.

Status flags are cleared by writing a one to them. Only two enable bits can be stored. The power-management interrupt is computed from pairs of matching enable and status bits. It is an active-low, level-sensitive output.

A power-button event input sets the power-button status flag, but only once ACPI mode is on. Firmware turns ACPI mode on and off by writing byte commands to the command port. The same ACPI-on flag appears as bit 0 of the control word. A timer-overflow input is shown as status bit 0. A control write that sets the sleep-enable bit together with the soft-off sleep type produces a single-cycle soft-off request.

Top module: `pmfix_regs`

## Requirements
- R1: After reset, the status, enable and control words all read 0x0000, `sci_n` is high, `soft_off` is low and ACPI mode is off.
- R2: The status word (0x400), the enable word (0x402) and the control word (0x404) must be accessed with size 2. A write to the command port (0xB2) must have size 1. Any other size raises `io_err` in the cycle of the strobe, returns read data 0 and changes no state.
- R3: A status write clears each bit written as 1 among bits 15, 10, 9, 8 and 4, and leaves every other status bit unchanged. Status bit 0 reads the level of `tmr_ovf` sampled at the previous clock edge, and writes cannot clear it.
- R4: An enable write keeps only bit 8 (power-button enable) and bit 5 (global enable). Every other bit is stored as 0, including bit 0 (timer enable).
- R5: `sci_n` is low exactly while at least one of the bit pairs 0, 5, 8, 9 or 10 has both its enable bit and its status bit at 1. It is registered, so it changes at the clock edge that updates the registers.
- R6: A command-port write of 0xA0 turns ACPI mode on. Control bit 0 then reads 1 and the power-button input is armed. A write of 0xA1 turns ACPI mode off, clears control bit 0 and disarms the input. Any other byte leaves both unchanged.
- R7: A `pwrbtn_evt` cycle sets status bit 8 only while ACPI mode is on. A repeated event while the bit is already set leaves it unchanged. If the event arrives in the same cycle as a status write that clears bit 8, the bit ends up set.
- R8: A control write cannot change control bit 0. Bits 15, 14, 13 and 1 are stored as 0. Bits 12 to 2, which include the sleep-type field at bits 12:10, are stored as written.
- R9: A size-2 control write with bit 13 set and bits 12:10 equal to 5 makes `soft_off` high for exactly the one cycle after the write edge. No other write makes it high.
- R10: A read of the command port returns 0x00FF with no error. A write to an address not listed in R2 changes nothing and raises no error. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational in the strobe cycle |
| io_err | output | 1 | Access rejected for size, combinational |
| pwrbtn_evt | input | 1 | Power-button event, one cycle per press |
| tmr_ovf | input | 1 | Timer overflow status level |
| sci_n | output | 1 | Power-management interrupt, active low, level |
| soft_off | output | 1 | Soft-off request pulse |

## Verification
The hardest case to reach from the ports is a button event landing in the same cycle as the status write that clears the power-button flag. Two orderings are plausible here, and only one is correct. The bench first raises the flag through an armed press. It then raises the event strobe and the clearing write strobe on the same falling edge. Finally it reads the status word back to show that the set won. A second hard case is proving that the timer and global pairs cannot raise the interrupt: the bench holds the timer-overflow level high while it writes every enable bit, then checks that `sci_n` stays high.

// File: rtl/pmfix_pkg.sv
package pmfix_pkg;
    localparam int REG_W = 16;

    // status bits that software may clear by writing one
    localparam logic [REG_W-1:0] STS_W1C   = 16'h8710;
    // enable bits that are retained on a write
    localparam logic [REG_W-1:0] EN_KEEP   = 16'h0120;
    // control bits never stored from a write (bit 0 comes from the mode flag)
    localparam logic [REG_W-1:0] CTL_DROP  = 16'hE003;
    localparam int               SLP_EN_B  = 13;
    localparam int               SLP_TYP_L = 10;
    localparam int               PWRBTN_B  = 8;
    localparam int               TMR_B     = 0;

    // enable/status pairs that can raise the interrupt
    localparam int NPAIR = 5;
    localparam logic [NPAIR-1:0][3:0] PAIR_BITS = {4'd10, 4'd9, 4'd8, 4'd5, 4'd0};

    function automatic logic [REG_W-1:0] pair_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NPAIR; i++) m[PAIR_BITS[i]] = 1'b1;
        return m;
    endfunction

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_CTL,
        SEL_CMD
    } sel_t;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
        logic             acpi_on;
        logic             soff;
    } pm_state_t;
endpackage

// File: rtl/pmfix_decode.sv
module pmfix_decode
    import pmfix_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 3,
    parameter logic [ADDR_W-1:0] EVT_BASE = 'h0400,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 'h0404,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'h00B2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              rd,
    input  logic              wr,
    output sel_t              sel,
    output logic              size_bad
);
    localparam logic [ADDR_W-1:0] EN_ADDR = EVT_BASE + ADDR_W'(2);
    localparam logic [SIZE_W-1:0] SZ_WORD = SIZE_W'(2);
    localparam logic [SIZE_W-1:0] SZ_BYTE = SIZE_W'(1);

    always_comb begin
        if (addr == EVT_BASE)      sel = SEL_STS;
        else if (addr == EN_ADDR)  sel = SEL_EN;
        else if (addr == CTL_ADDR) sel = SEL_CTL;
        else if (addr == CMD_ADDR) sel = SEL_CMD;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        case (sel)
            SEL_STS, SEL_EN, SEL_CTL: size_bad = (rd | wr) && (size != SZ_WORD);
            SEL_CMD:                  size_bad = wr && (size != SZ_BYTE);
            default:                  size_bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmfix_sci.sv
module pmfix_sci
    import pmfix_pkg::*;
(
    input  logic [REG_W-1:0] sts,
    input  logic [REG_W-1:0] en,
    output logic             need
);
    localparam logic [REG_W-1:0] PMASK = pair_mask();

    logic [REG_W-1:0] both;
    logic [NPAIR-1:0] hit;

    assign both = sts & en & PMASK;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign hit[g] = both[PAIR_BITS[g]];
    end

    assign need = |hit;
endmodule

// File: rtl/pmfix_regs.sv
module pmfix_regs
    import pmfix_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 3,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] EVT_BASE = 'h0400,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 'h0404,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'h00B2,
    parameter logic [7:0] CMD_ON  = 8'hA0,
    parameter logic [7:0] CMD_OFF = 8'hA1,
    parameter logic [2:0] SOFF_TYP = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [SIZE_W-1:0] io_size,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_err,
    input  logic              pwrbtn_evt,
    input  logic              tmr_ovf,
    output logic              sci_n,
    output logic              soft_off
);
    localparam logic [DATA_W-1:0] CMD_RDVAL = DATA_W'(8'hFF);

    sel_t             sel;
    logic             size_bad;
    logic             wr_go;
    logic             need_sci;
    logic [REG_W-1:0] wd;
    pm_state_t        q, d;
    logic             sci_q;

    assign wd = io_wdata[REG_W-1:0];

    pmfix_decode #(
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W),
        .EVT_BASE(EVT_BASE),
        .CTL_ADDR(CTL_ADDR),
        .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .addr    (io_addr),
        .size    (io_size),
        .rd      (io_rd),
        .wr      (io_wr),
        .sel     (sel),
        .size_bad(size_bad)
    );

    assign wr_go  = io_wr && !size_bad;
    assign io_err = size_bad;

    // next-state computation
    always_comb begin
        d          = q;
        d.soff     = 1'b0;
        d.sts[TMR_B] = tmr_ovf;
        if (wr_go) begin
            case (sel)
                SEL_STS: d.sts = {q.sts[REG_W-1:1] & ~(wd[REG_W-1:1] & STS_W1C[REG_W-1:1]), tmr_ovf};
                SEL_EN:  d.en  = wd & EN_KEEP;
                SEL_CTL: begin
                    d.ctl  = wd & ~CTL_DROP;
                    d.soff = wd[SLP_EN_B] && (wd[SLP_TYP_L+2:SLP_TYP_L] == SOFF_TYP);
                end
                SEL_CMD: begin
                    if (wd[7:0] == CMD_ON)       d.acpi_on = 1'b1;
                    else if (wd[7:0] == CMD_OFF) d.acpi_on = 1'b0;
                end
                default: ;
            endcase
        end
        // an armed press wins over a clearing write in the same cycle
        if (pwrbtn_evt && q.acpi_on) d.sts[PWRBTN_B] = 1'b1;
    end

    pmfix_sci u_sci (
        .sts (d.sts),
        .en  (d.en),
        .need(need_sci)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            sci_q <= 1'b1;
        end else begin
            q     <= d;
            sci_q <= ~need_sci;
        end
    end

    // read return
    always_comb begin
        io_rdata = '0;
        if (io_rd && !size_bad) begin
            case (sel)
                SEL_STS: io_rdata = DATA_W'(q.sts);
                SEL_EN:  io_rdata = DATA_W'(q.en);
                SEL_CTL: io_rdata = DATA_W'({q.ctl[REG_W-1:1], q.acpi_on});
                SEL_CMD: io_rdata = CMD_RDVAL;
                default: io_rdata = '0;
            endcase
        end
    end

    assign sci_n    = sci_q;
    assign soft_off = q.soff;
endmodule

// File: rtl/pmfix_chk.sv
module pmfix_chk #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 3,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] EVT_BASE = 'h0400,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 'h0404,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'h00B2,
    parameter logic [7:0] CMD_ON = 8'hA0,
    parameter logic [2:0] SOFF_TYP = 3'd5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [SIZE_W-1:0] io_size,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic              sci_n,
    input logic              soft_off,
    input logic [15:0]       en_q,
    input logic [15:0]       sts_q,
    input logic              acpi_on_q
);
    localparam logic [ADDR_W-1:0] EN_ADDR = EVT_BASE + ADDR_W'(2);

    // R9: the request lasts one cycle
    p_soff_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_off |=> !soft_off);

    // R9: the request follows a qualifying control write
    p_soff_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_off) |-> $past(io_wr && io_addr == CTL_ADDR && io_size == SIZE_W'(2)
                                  && io_wdata[13] && io_wdata[12:10] == SOFF_TYP));

    // R2: a wrongly sized enable write changes nothing
    p_badsize_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == EN_ADDR && io_size != SIZE_W'(2)) |=> $stable(en_q));

    // R4: an accepted enable write keeps only the two allowed bits
    p_en_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == EN_ADDR && io_size == SIZE_W'(2)) |=> en_q == ($past(io_wdata[15:0]) & 16'h0120));

    // R7: without ACPI mode the button flag cannot appear
    p_btn_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acpi_on_q && !sts_q[8]) |=> !sts_q[8]);

    // R5: the interrupt can only go active through the power-button pair
    p_sci_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sci_n) |-> (en_q[8] && sts_q[8]));

    // R6: the enable command turns ACPI mode on
    p_cmd_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == CMD_ADDR && io_size == SIZE_W'(1) && io_wdata[7:0] == CMD_ON) |=> acpi_on_q);
endmodule

bind pmfix_regs pmfix_chk #(
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .DATA_W  (DATA_W),
    .EVT_BASE(EVT_BASE),
    .CTL_ADDR(CTL_ADDR),
    .CMD_ADDR(CMD_ADDR),
    .CMD_ON  (CMD_ON),
    .SOFF_TYP(SOFF_TYP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_size  (io_size),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .sci_n    (sci_n),
    .soft_off (soft_off),
    .en_q     (q.en),
    .sts_q    (q.sts),
    .acpi_on_q(q.acpi_on)
);

// File: tb/sim_pmfix_regs.sv
module sim_pmfix_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_STS = 16'h0400;
    localparam logic [15:0] A_EN  = 16'h0402;
    localparam logic [15:0] A_CTL = 16'h0404;
    localparam logic [15:0] A_CMD = 16'h00B2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [2:0]  io_size = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        io_err;
    logic        pwrbtn_evt = 1'b0;
    logic        tmr_ovf = 1'b0;
    logic        sci_n;
    logic        soft_off;

    int total = 0;
    int bad = 0;
    logic        last_err;
    logic        last_soff;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmfix_regs u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_err(io_err), .pwrbtn_evt(pwrbtn_evt), .tmr_ovf(tmr_ovf),
        .sci_n(sci_n), .soft_off(soft_off)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [2:0] s, input logic [15:0] dat);
        @(negedge clk);
        io_addr = a; io_size = s; io_wdata = dat; io_wr = 1'b1;
        #1 last_err = io_err;
        @(negedge clk);
        io_wr = 1'b0;
        #1 last_soff = soft_off;
    endtask

    task automatic rd(input logic [15:0] a, input logic [2:0] s, output logic [15:0] val);
        @(negedge clk);
        io_addr = a; io_size = s; io_rd = 1'b1;
        #1 val = io_rdata; last_err = io_err;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic press();
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rd(A_STS, 3'd2, rv); chk("R1 status after reset", rv, 16'h0000);
        rd(A_EN, 3'd2, rv);  chk("R1 enable after reset", rv, 16'h0000);
        rd(A_CTL, 3'd2, rv); chk("R1 control after reset", rv, 16'h0000);
        chk("R1 sci_n after reset", {15'd0, sci_n}, 16'h0001);
        chk("R1 soft_off after reset", {15'd0, soft_off}, 16'h0000);
        press();
        rd(A_STS, 3'd2, rv); chk("R7 press while disarmed", rv, 16'h0000);
    endtask

    task automatic t_size();
        wr(A_EN, 3'd1, 16'h0100); chk("R2 err on byte enable write", {15'd0, last_err}, 16'h0001);
        rd(A_EN, 3'd2, rv);       chk("R2 enable unchanged", rv, 16'h0000);
        rd(A_STS, 3'd4, rv);      chk("R2 err on dword status read", {15'd0, last_err}, 16'h0001);
        chk("R2 rejected read data", rv, 16'h0000);
        wr(A_CMD, 3'd2, 16'h00A0); chk("R2 err on word command write", {15'd0, last_err}, 16'h0001);
        rd(A_CTL, 3'd2, rv);      chk("R2 mode unchanged", rv, 16'h0000);
    endtask

    task automatic t_enable();
        wr(A_EN, 3'd2, 16'hFFFF); chk("R4 no err", {15'd0, last_err}, 16'h0000);
        rd(A_EN, 3'd2, rv);       chk("R4 enable mask", rv, 16'h0120);
        wr(A_EN, 3'd2, 16'h0001);
        rd(A_EN, 3'd2, rv);       chk("R4 timer enable dropped", rv, 16'h0000);
    endtask

    task automatic t_cmd();
        wr(A_CMD, 3'd1, 16'h0055);
        rd(A_CTL, 3'd2, rv);      chk("R6 other byte no effect", rv, 16'h0000);
        wr(A_CMD, 3'd1, 16'h00A0);
        rd(A_CTL, 3'd2, rv);      chk("R6 enable command", rv, 16'h0001);
    endtask

    task automatic t_button();
        wr(A_EN, 3'd2, 16'h0100);
        chk("R5 sci idle with enable only", {15'd0, sci_n}, 16'h0001);
        press();
        chk("R5 sci active after press", {15'd0, sci_n}, 16'h0000);
        rd(A_STS, 3'd2, rv);      chk("R7 armed press sets flag", rv, 16'h0100);
        press();
        rd(A_STS, 3'd2, rv);      chk("R7 repeated press", rv, 16'h0100);
    endtask

    task automatic t_w1c();
        wr(A_STS, 3'd2, 16'h86FF);
        rd(A_STS, 3'd2, rv);      chk("R3 write without bit 8 keeps it", rv, 16'h0100);
        chk("R5 sci still active", {15'd0, sci_n}, 16'h0000);
        wr(A_STS, 3'd2, 16'h0100);
        chk("R5 sci released after clear", {15'd0, sci_n}, 16'h0001);
        rd(A_STS, 3'd2, rv);      chk("R3 bit 8 cleared", rv, 16'h0000);
        tmr_ovf = 1'b1;
        rd(A_STS, 3'd2, rv);      chk("R3 timer level shown", rv, 16'h0001);
        wr(A_STS, 3'd2, 16'hFFFF);
        rd(A_STS, 3'd2, rv);      chk("R3 timer bit not cleared", rv, 16'h0001);
        wr(A_EN, 3'd2, 16'hFFFF);
        chk("R5 timer and global pairs cannot assert", {15'd0, sci_n}, 16'h0001);
        tmr_ovf = 1'b0;
        wr(A_EN, 3'd2, 16'h0000);
    endtask

    task automatic t_race();
        press();
        @(negedge clk);
        io_addr = A_STS; io_size = 3'd2; io_wdata = 16'h0100; io_wr = 1'b1; pwrbtn_evt = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; pwrbtn_evt = 1'b0;
        rd(A_STS, 3'd2, rv);      chk("R7 press beats clear", rv, 16'h0100);
        wr(A_STS, 3'd2, 16'h0100);
    endtask

    task automatic t_ctrl();
        wr(A_CTL, 3'd2, 16'hFFFF);
        rd(A_CTL, 3'd2, rv);      chk("R8 control mask with mode on", rv, 16'h1FFD);
        wr(A_CTL, 3'd2, 16'h0000);
        rd(A_CTL, 3'd2, rv);      chk("R8 bit 0 kept on write", rv, 16'h0001);
        wr(A_CMD, 3'd1, 16'h00A1);
        rd(A_CTL, 3'd2, rv);      chk("R6 disable command", rv, 16'h0000);
        wr(A_CTL, 3'd2, 16'h0001);
        rd(A_CTL, 3'd2, rv);      chk("R8 write cannot set bit 0", rv, 16'h0000);
        press();
        rd(A_STS, 3'd2, rv);      chk("R6 disarmed after disable", rv, 16'h0000);
    endtask

    task automatic t_soff();
        wr(A_CTL, 3'd2, 16'h3400);
        chk("R9 pulse high", {15'd0, last_soff}, 16'h0001);
        @(negedge clk); #1;
        chk("R9 pulse one cycle", {15'd0, soft_off}, 16'h0000);
        rd(A_CTL, 3'd2, rv);      chk("R8 sleep type stored", rv, 16'h1400);
        wr(A_CTL, 3'd2, 16'h1400);
        chk("R9 no pulse without sleep enable", {15'd0, last_soff}, 16'h0000);
        wr(A_CTL, 3'd2, 16'h2C00);
        chk("R9 no pulse for other type", {15'd0, last_soff}, 16'h0000);
        wr(A_CTL, 3'd1, 16'h3400);
        chk("R9 no pulse on rejected size", {15'd0, last_soff}, 16'h0000);
    endtask

    task automatic t_misc();
        rd(A_CMD, 3'd1, rv);      chk("R10 command read value", rv, 16'h00FF);
        chk("R10 command read no err", {15'd0, last_err}, 16'h0000);
        wr(16'h0406, 3'd2, 16'hFFFF);
        chk("R10 unmapped write no err", {15'd0, last_err}, 16'h0000);
        rd(16'h0406, 3'd2, rv);   chk("R10 unmapped read", rv, 16'h0000);
        rd(A_EN, 3'd2, rv);       chk("R10 enable untouched", rv, 16'h0000);
        rd(A_CTL, 3'd2, rv);      chk("R10 control untouched", rv, 16'h2C00 & 16'h1FFC);
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_size();
        t_enable();
        t_cmd();
        t_button();
        t_w1c();
        t_race();
        t_ctrl();
        t_soff();
        t_misc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule